// File: doc/BRIEF.md
# Sound Command Mailbox

This block passes one-byte commands from a 16-bit main processor to an 8-bit sound processor and passes one-byte results back. When the main side writes a command, the block latches the upper data byte and requests a non-maskable interrupt on the sound side. The sound side fetches the command from an I/O port, and that read withdraws the request. The sound side also writes a result byte to a second port, and the main side sees that byte in the upper half of a 16-bit input word.

Two further sound-side ports carry no data. One of them enables the interrupt output and the other disables it. While the output is disabled, a command that arrives is still recorded as pending. The output rises as soon as the interrupt is enabled again.

A four-state machine holds the interrupt status. `ST_ARMED_IDLE` means the interrupt is enabled and no command is pending. `ST_ARMED_PEND` means it is enabled and a command is unread; this is the only state that drives `snd_nmi` high. `ST_MUTED_IDLE` means it is disabled with nothing pending. `ST_MUTED_PEND` means it is disabled with a command unread.

The transitions are as follows:
- *post*: a command write moves the machine to the pending state of the same enable mode.
- *take*: a command read with no command write in the same cycle moves it to the idle state of the same mode.
- *arm*: a write to the enable port moves a muted state to the armed state with the same pending status.
- *mute*: a write to the disable port moves an armed state to the muted state with the same pending status.

Top module: `snd_mailbox`

## Requirements
- R1: A main write whose byte-lane mask `main_be` is `2'b01` leaves the command unchanged and raises no interrupt. Bit 1 of the mask is the upper lane and bit 0 is the lower lane.
- R2: A main write with any other mask, `2'b00` included, latches `main_wdata[15:8]` as the command.
- R3: When the interrupt is enabled, a latched command drives `snd_nmi` high from the clock edge that takes the write. The level stays high until a read or a disable lowers it.
- R4: A sound read (`snd_io_rd`) at port 0x00 returns the command on `snd_io_rdata` in the same cycle. `snd_nmi` is low after that edge, unless a command write happens in the same cycle. All other reads return 0.
- R5: A sound write at port 0x0C stores `snd_io_wdata`. From the next edge, `main_result_word[15:8]` shows the stored byte and `main_result_word[7:0]` is 0.
- R6: A sound write at port 0x18 forces `snd_nmi` low from the next edge and keeps any unread command pending. The data value has no effect.
- R7: A sound write at port 0x08 enables the interrupt, so a pending command drives `snd_nmi` high from the next edge. This write does not clear the pending command, and its data value has no effect.
- R8: After reset the command and result are 0, `snd_nmi` is low and the interrupt is enabled.
- R9: A command written while the previous one is unread replaces it and `snd_nmi` stays high. If a write and a read fall in the same cycle, the read returns the old command and the new command is left pending.
- R10: Port decoding uses only `snd_io_addr[7:0]`. Writes to any other port change neither the result nor the interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_wr | input | 1 | Main-side command write strobe |
| main_be | input | 2 | Byte lanes of the write (bit 1 upper, bit 0 lower) |
| main_wdata | input | 16 | Main-side write data; bits 15:8 carry the command |
| main_result_word | output | 16 | Result byte in bits 15:8, zero in bits 7:0 |
| snd_io_rd | input | 1 | Sound-side I/O read strobe |
| snd_io_wr | input | 1 | Sound-side I/O write strobe |
| snd_io_addr | input | 16 | Sound-side I/O address; only bits 7:0 are decoded |
| snd_io_wdata | input | 8 | Sound-side I/O write data |
| snd_io_rdata | output | 8 | Command byte during a read of port 0x00, else 0 |
| snd_nmi | output | 1 | Interrupt request level toward the sound processor |

## Verification
A wrong enable bit shows up as `snd_nmi` having the wrong level one edge after the next command write. It can stay hidden until a command is pending, so the bench sets up the disable, then the command, then the enable, in that order. A lost or spurious pending bit shows up at `snd_nmi` one edge after the stimulus. A wrong command byte shows up only at the next read of port 0x00, so every command write is followed by a read within a few cycles. A result fault shows up on `main_result_word` one edge after the port write.

// File: rtl/snd_mbox_pkg.sv
package snd_mbox_pkg;
    // bit 1: interrupt muted, bit 0: command pending
    typedef enum logic [1:0] {
        ST_ARMED_IDLE = 2'b00,
        ST_ARMED_PEND = 2'b01,
        ST_MUTED_IDLE = 2'b10,
        ST_MUTED_PEND = 2'b11
    } mbox_state_t;
endpackage

// File: rtl/snd_port_decode.sv
module snd_port_decode #(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8,
    parameter logic [PORT_W-1:0] CMD_PORT = 8'h00,
    parameter logic [PORT_W-1:0] RES_PORT = 8'h0C,
    parameter logic [PORT_W-1:0] EN_PORT  = 8'h08,
    parameter logic [PORT_W-1:0] DIS_PORT = 8'h18
) (
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              cmd_rd,
    output logic              res_wr,
    output logic              en_wr,
    output logic              dis_wr
);
    logic [PORT_W-1:0] port;
    logic              unused_hi;

    assign port      = io_addr[PORT_W-1:0];
    assign unused_hi = ^io_addr[ADDR_W-1:PORT_W];

    assign cmd_rd = io_rd && (port == CMD_PORT);
    assign res_wr = io_wr && (port == RES_PORT);
    assign en_wr  = io_wr && (port == EN_PORT);
    assign dis_wr = io_wr && (port == DIS_PORT);
endmodule

// File: rtl/snd_byte_reg.sv
module snd_byte_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/snd_nmi_fsm.sv
module snd_nmi_fsm
    import snd_mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic take,
    input  logic arm,
    input  logic mute,
    output logic nmi,
    output logic armed
);
    mbox_state_t state, state_nx;
    logic        pend_nx;

    // a post in the same cycle as a take wins: the new command stays pending
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED_IDLE: begin
                pend_nx  = post;
                state_nx = mute ? (pend_nx ? ST_MUTED_PEND : ST_MUTED_IDLE)
                                : (pend_nx ? ST_ARMED_PEND : ST_ARMED_IDLE);
            end
            ST_ARMED_PEND: begin
                pend_nx  = post || !take;
                state_nx = mute ? (pend_nx ? ST_MUTED_PEND : ST_MUTED_IDLE)
                                : (pend_nx ? ST_ARMED_PEND : ST_ARMED_IDLE);
            end
            ST_MUTED_IDLE: begin
                pend_nx  = post;
                state_nx = arm ? (pend_nx ? ST_ARMED_PEND : ST_ARMED_IDLE)
                               : (pend_nx ? ST_MUTED_PEND : ST_MUTED_IDLE);
            end
            ST_MUTED_PEND: begin
                pend_nx  = post || !take;
                state_nx = arm ? (pend_nx ? ST_ARMED_PEND : ST_ARMED_IDLE)
                               : (pend_nx ? ST_MUTED_PEND : ST_MUTED_IDLE);
            end
            default: begin
                pend_nx  = 1'b0;
                state_nx = ST_ARMED_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ARMED_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_ARMED_IDLE: begin nmi = 1'b0; armed = 1'b1; end
            ST_ARMED_PEND: begin nmi = 1'b1; armed = 1'b1; end
            ST_MUTED_IDLE: begin nmi = 1'b0; armed = 1'b0; end
            ST_MUTED_PEND: begin nmi = 1'b0; armed = 1'b0; end
            default:       begin nmi = 1'b0; armed = 1'b1; end
        endcase
    end
endmodule

// File: rtl/snd_mailbox.sv
module snd_mailbox #(
    parameter int MAIN_W = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     main_wr,
    input  logic [MAIN_W/BYTE_W-1:0] main_be,
    input  logic [MAIN_W-1:0]        main_wdata,
    output logic [MAIN_W-1:0]        main_result_word,
    input  logic                     snd_io_rd,
    input  logic                     snd_io_wr,
    input  logic [ADDR_W-1:0]        snd_io_addr,
    input  logic [BYTE_W-1:0]        snd_io_wdata,
    output logic [BYTE_W-1:0]        snd_io_rdata,
    output logic                     snd_nmi
);
    localparam int LANES = MAIN_W / BYTE_W;
    localparam logic [LANES-1:0] LOW_ONLY = LANES'(1);

    logic              main_accept;
    logic              cmd_rd, res_wr, en_wr, dis_wr;
    logic              armed;
    logic [BYTE_W-1:0] cmd_q, res_q;
    logic              unused_low;

    assign main_accept = main_wr && (main_be != LOW_ONLY);
    assign unused_low  = ^main_wdata[MAIN_W-BYTE_W-1:0];

    snd_port_decode #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_dec (
        .io_rd   (snd_io_rd),
        .io_wr   (snd_io_wr),
        .io_addr (snd_io_addr),
        .cmd_rd  (cmd_rd),
        .res_wr  (res_wr),
        .en_wr   (en_wr),
        .dis_wr  (dis_wr)
    );

    snd_byte_reg #(.W(BYTE_W)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (main_accept),
        .d     (main_wdata[MAIN_W-1 -: BYTE_W]),
        .q     (cmd_q)
    );

    snd_byte_reg #(.W(BYTE_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (res_wr),
        .d     (snd_io_wdata),
        .q     (res_q)
    );

    snd_nmi_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .post  (main_accept),
        .take  (cmd_rd),
        .arm   (en_wr),
        .mute  (dis_wr),
        .nmi   (snd_nmi),
        .armed (armed)
    );

    assign snd_io_rdata     = cmd_rd ? cmd_q : '0;
    assign main_result_word = {res_q, {(MAIN_W-BYTE_W){1'b0}}};
endmodule

// File: rtl/snd_mailbox_chk.sv
module snd_mailbox_chk #(
    parameter int MAIN_W = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     main_wr,
    input logic [MAIN_W/BYTE_W-1:0] main_be,
    input logic [MAIN_W-1:0]        main_wdata,
    input logic [MAIN_W-1:0]        main_result_word,
    input logic                     snd_io_rd,
    input logic                     snd_io_wr,
    input logic [ADDR_W-1:0]        snd_io_addr,
    input logic [BYTE_W-1:0]        snd_io_wdata,
    input logic                     snd_nmi,
    input logic [BYTE_W-1:0]        cmd_q,
    input logic                     armed
);
    localparam int LANES = MAIN_W / BYTE_W;
    logic [PORT_W-1:0] pt;
    logic acc, rd0, wr_res, wr_dis;
    assign pt     = snd_io_addr[PORT_W-1:0];
    assign acc    = main_wr && (main_be != LANES'(1));
    assign rd0    = snd_io_rd && (pt == PORT_W'(8'h00));
    assign wr_res = snd_io_wr && (pt == PORT_W'(8'h0C));
    assign wr_dis = snd_io_wr && (pt == PORT_W'(8'h18));

    assert_lowlane_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (main_wr && main_be == LANES'(1)) |=> cmd_q == $past(cmd_q));
    assert_cmd_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> cmd_q == $past(main_wdata[MAIN_W-1 -: BYTE_W]));
    assert_nmi_raised_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && armed && !wr_dis) |=> snd_nmi);
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !acc) |=> !snd_nmi);
    assert_result_shown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_res |=> main_result_word[MAIN_W-1 -: BYTE_W] == $past(snd_io_wdata));
    assert_result_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        main_result_word[MAIN_W-BYTE_W-1:0] == '0);
    assert_mute_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> !snd_nmi);
    assert_overwrite_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && snd_nmi && !wr_dis) |=> snd_nmi);
endmodule

bind snd_mailbox snd_mailbox_chk #(
    .MAIN_W(MAIN_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .main_wr(main_wr), .main_be(main_be),
    .main_wdata(main_wdata), .main_result_word(main_result_word),
    .snd_io_rd(snd_io_rd), .snd_io_wr(snd_io_wr), .snd_io_addr(snd_io_addr),
    .snd_io_wdata(snd_io_wdata), .snd_nmi(snd_nmi), .cmd_q(cmd_q), .armed(armed)
);

// File: tb/sim_snd_mailbox.sv
module sim_snd_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        main_wr = 1'b0;
    logic [1:0]  main_be = 2'b00;
    logic [15:0] main_wdata = '0;
    logic [15:0] main_result_word;
    logic        snd_io_rd = 1'b0;
    logic        snd_io_wr = 1'b0;
    logic [15:0] snd_io_addr = '0;
    logic [7:0]  snd_io_wdata = '0;
    logic [7:0]  snd_io_rdata;
    logic        snd_nmi;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int ref_cmd = 0, ref_res = 0;
    bit ref_pend = 0, ref_en = 1;

    always #10 clk = ~clk;

    snd_mailbox u0 (.*);

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, check read data, update model, check after edge
    task automatic step(string tag, bit mw, bit [1:0] be, bit [15:0] wd,
                        bit rd, bit wr, bit [15:0] addr, bit [7:0] iwd);
        int port;
        bit acc;
        @(negedge clk);
        main_wr = mw; main_be = be; main_wdata = wd;
        snd_io_rd = rd; snd_io_wr = wr; snd_io_addr = addr; snd_io_wdata = iwd;
        #2;
        port = int'(addr) % 256;
        acc = mw && (be != 2'b01);
        check(tag, "rdata", int'(snd_io_rdata), (rd && port == 0) ? ref_cmd : 0);
        if (wr && port == 12) ref_res = int'(iwd);
        if (wr && port == 8)  ref_en = 1;
        if (wr && port == 24) ref_en = 0;
        if (acc) begin
            ref_cmd = int'(wd) / 256;
            ref_pend = 1;
        end else if (rd && port == 0) ref_pend = 0;
        @(posedge clk);
        #2;
        check(tag, "nmi", int'(snd_nmi), int'(ref_pend && ref_en));
        check(tag, "result", int'(main_result_word), ref_res * 256);
        main_wr = 0; snd_io_rd = 0; snd_io_wr = 0;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 2'b00, 16'h0, 0, 0, 16'h0, 8'h0);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R8", "nmi", int'(snd_nmi), 0);
        check("R8", "result", int'(main_result_word), 0);
        @(negedge clk); rst_n = 1'b1;
        step("R8", 0, 2'b00, 16'h0, 1, 0, 16'h0000, 8'h0);            // reset command reads 0
        step("R1", 1, 2'b01, 16'hAB12, 0, 0, 16'h0, 8'h0);           // lower lane only: ignored
        step("R1", 0, 2'b00, 16'h0, 1, 0, 16'h0000, 8'h0);           // command still 0
        step("R3", 1, 2'b11, 16'h5A00, 0, 0, 16'h0, 8'h0);           // R2 latch, R3 nmi high
        idle("R3");
        step("R4", 0, 2'b00, 16'h0, 1, 0, 16'hFF00, 8'h0);           // R10 upper address ignored
        idle("R4");
        step("R2", 1, 2'b10, 16'h3301, 0, 0, 16'h0, 8'h0);
        step("R9", 1, 2'b11, 16'h77FF, 0, 0, 16'h0, 8'h0);           // overwrite while unread
        step("R9", 0, 2'b00, 16'h0, 1, 0, 16'h0100, 8'h0);
        step("R2", 1, 2'b00, 16'h9C00, 0, 0, 16'h0, 8'h0);           // no lanes still latches
        step("R9", 1, 2'b11, 16'hE400, 1, 0, 16'h0000, 8'h0);        // write and read together
        step("R9", 0, 2'b00, 16'h0, 1, 0, 16'h0000, 8'h0);
        step("R6", 0, 2'b00, 16'h0, 0, 1, 16'hAB18, 8'h5D);          // disable, data ignored
        step("R6", 1, 2'b11, 16'h4200, 0, 0, 16'h0, 8'h0);           // pending but muted
        idle("R6");
        step("R7", 0, 2'b00, 16'h0, 0, 1, 16'h3408, 8'hFF);          // enable brings nmi back
        step("R7", 0, 2'b00, 16'h0, 0, 1, 16'h0008, 8'h00);          // enable again keeps pending
        step("R6", 0, 2'b00, 16'h0, 0, 1, 16'h0018, 8'h00);
        step("R7", 0, 2'b00, 16'h0, 0, 1, 16'h0008, 8'h00);
        step("R4", 0, 2'b00, 16'h0, 1, 0, 16'h0000, 8'h0);
        step("R5", 0, 2'b00, 16'h0, 0, 1, 16'h120C, 8'hC3);
        step("R10", 0, 2'b00, 16'h0, 0, 1, 16'h000D, 8'h11);         // unused port ignored
        step("R10", 0, 2'b00, 16'h0, 1, 0, 16'h000C, 8'h0);          // read of other port gives 0
        step("R5", 0, 2'b00, 16'h0, 0, 1, 16'hFF0C, 8'h3E);
        step("R10", 1, 2'b11, 16'h6600, 0, 1, 16'h0028, 8'h00);      // 0x28 is not disable
        step("R4", 0, 2'b00, 16'h0, 1, 0, 16'h0000, 8'h0);
        for (int i = 0; i < 16; i++)
            step("R2", (i % 3) != 0, 2'(i), 16'(i * 16'h1111), (i % 4) == 1, 0, 16'h0, 8'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule